// File: doc/BRIEF.md
# Opcode-Decoded 8-bit ALU with Condition Flags

This block performs one arithmetic or logic operation per transfer on two 8-bit operands. The operation is chosen directly by an 8-bit instruction opcode. Unary operations sit in the low nibble of the opcode with the high nibble zero. Binary operations sit in the high nibble with the low nibble zero. Besides the 8-bit result, it produces a five-bit condition word that the surrounding core writes into its flag register. It also produces a write-enable hint that tells the core whether the result belongs in a destination register.

Operands arrive on a valid/ready input stream, and results leave on a valid/ready output stream one cycle later. The current flag-register value rides along with each request, so an opcode the block does not recognise hands those flags back untouched. Back-pressure is simple. The input is accepted whenever the output slot is empty or is being drained in the same cycle. A result held while `out_ready` is low keeps every output bit stable until it is taken. Apart from that single output slot, the block keeps no state.

Top module: `opc_alu`

## Requirements
- R1: A request is taken on a rising edge where `in_valid` and `in_ready` are both high, and its response is presented with `out_valid` high after that edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_result`, `out_flags` and `out_wr` stay stable. Responses leave in request order.
- R2: Opcode 0x01 gives A+1, 0x02 gives A-1 and 0x03 gives ~A, and operand B is ignored. For 0x01, carry is set when A is 0xFF and overflow when A is 0x7F. For 0x02, carry (borrow) is set when A is 0x00 and overflow when A is 0x80. For 0x03, carry and overflow are cleared.
- R3: Opcode 0x10 gives A+B, with carry as the unsigned carry-out and overflow as two's-complement overflow. Opcode 0x20 gives A-B, with carry set when A < B unsigned and overflow as two's-complement overflow of the difference.
- R4: Opcode 0x30 gives the low byte of A*B. Carry is set when the high byte of the product is non-zero, and overflow is cleared.
- R5: Opcode 0x40 gives the unsigned quotient A/B and 0x50 gives the remainder A%B, with carry and overflow cleared.
- R6: Opcodes 0x40 and 0x50 with B = 0 give the result 0xFF, set the divide-error flag, and clear carry and overflow.
- R7: Opcodes 0x60 AND, 0x70 OR, 0x80 XOR, 0x90 NAND, 0xA0 NOR and 0xB0 XNOR give the bitwise result, with carry and overflow cleared.
- R8: Opcode 0xC0 sets all flags as for A-B, so zero means equal and carry means A < B unsigned. Its result is 0x00 and `out_wr` is 0.
- R9: Any other opcode, including 0x00 and 0x04, gives the result 0x00 and `out_wr` = 0, and returns `in_flags` unchanged in `out_flags`.
- R10: For every listed opcode except 0xC0, `out_wr` is 1. Zero is set exactly when the result is 0x00, and sign equals result bit 7. The divide-error flag is cleared unless R6 applies.
- R11: The flag word is laid out as bit 0 zero, bit 1 carry, bit 2 sign, bit 3 overflow and bit 4 divide error. The same layout applies to `in_flags` and `out_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_opcode | input | 8 | Instruction opcode selecting the operation |
| in_a | input | 8 | Operand A |
| in_b | input | 8 | Operand B (divisor, subtrahend) |
| in_flags | input | 5 | Current flag-register value |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_result | output | 8 | Operation result |
| out_flags | output | 5 | New flag value |
| out_wr | output | 1 | Result should be written to a register |

## Verification
A mis-decoded opcode or a wrong operand steering path shows at the ports on the very next response. It appears as a wrong result byte, a flag bit in the wrong position, or a write-enable that contradicts the opcode class. The bench therefore sweeps every one of the 256 opcode values against a reference model, alongside hand-picked carry, overflow and zero-divisor corners. The only internal state is the output slot. If that slot is corrupted, a held response changes while stalled, or a response is lost or duplicated. The scoreboard detects either on the first response after the fault, because it checks the order and content of every delivered item while the consumer stalls in an irregular pattern.

// File: rtl/opc_alu_pkg.sv
package opc_alu_pkg;

  localparam int OPC_W  = 8;
  localparam int FLAG_W = 5;

  localparam logic [OPC_W-1:0] OPC_INC  = 8'h01;
  localparam logic [OPC_W-1:0] OPC_DEC  = 8'h02;
  localparam logic [OPC_W-1:0] OPC_NOT  = 8'h03;
  localparam logic [OPC_W-1:0] OPC_ADD  = 8'h10;
  localparam logic [OPC_W-1:0] OPC_SUB  = 8'h20;
  localparam logic [OPC_W-1:0] OPC_MUL  = 8'h30;
  localparam logic [OPC_W-1:0] OPC_DIV  = 8'h40;
  localparam logic [OPC_W-1:0] OPC_MOD  = 8'h50;
  localparam logic [OPC_W-1:0] OPC_AND  = 8'h60;
  localparam logic [OPC_W-1:0] OPC_OR   = 8'h70;
  localparam logic [OPC_W-1:0] OPC_XOR  = 8'h80;
  localparam logic [OPC_W-1:0] OPC_NAND = 8'h90;
  localparam logic [OPC_W-1:0] OPC_NOR  = 8'hA0;
  localparam logic [OPC_W-1:0] OPC_XNOR = 8'hB0;
  localparam logic [OPC_W-1:0] OPC_CMP  = 8'hC0;

  typedef enum logic [3:0] {
    OP_INC, OP_DEC, OP_NOT, OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD,
    OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR, OP_XNOR, OP_CMP, OP_NONE
  } alu_op_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic derr;
    logic ovf;
    logic neg;
    logic carry;
    logic zero;
  } alu_flags_t;

endpackage

// File: rtl/opc_alu_decode.sv
module opc_alu_decode
  import opc_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output alu_op_e          op
);
  localparam int NIB = OPC_W / 2;

  logic [NIB-1:0] hi_nib;
  logic [NIB-1:0] lo_nib;

  assign hi_nib = opcode[OPC_W-1:NIB];
  assign lo_nib = opcode[NIB-1:0];

  always_comb begin
    op = OP_NONE;
    if (hi_nib == '0) begin
      unique case (opcode)
        OPC_INC: op = OP_INC;
        OPC_DEC: op = OP_DEC;
        OPC_NOT: op = OP_NOT;
        default: op = OP_NONE;
      endcase
    end else if (lo_nib == '0) begin
      unique case (opcode)
        OPC_ADD:  op = OP_ADD;
        OPC_SUB:  op = OP_SUB;
        OPC_MUL:  op = OP_MUL;
        OPC_DIV:  op = OP_DIV;
        OPC_MOD:  op = OP_MOD;
        OPC_AND:  op = OP_AND;
        OPC_OR:   op = OP_OR;
        OPC_XOR:  op = OP_XOR;
        OPC_NAND: op = OP_NAND;
        OPC_NOR:  op = OP_NOR;
        OPC_XNOR: op = OP_XNOR;
        OPC_CMP:  op = OP_CMP;
        default:  op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/opc_alu_addsub.sv
module opc_alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          carry,
  output logic          ovf
);
  logic [DW-1:0] addend;
  logic          cout;

  assign addend = sub ? ~b : b;
  assign {cout, sum} = {1'b0, a} + {1'b0, addend} + {{DW{1'b0}}, sub};
  // carry for add, borrow for subtract
  assign carry = sub ? ~cout : cout;
  assign ovf   = (a[DW-1] == addend[DW-1]) && (sum[DW-1] != a[DW-1]);
endmodule

// File: rtl/opc_alu_muldiv.sv
module opc_alu_muldiv #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] prod_lo,
  output logic          prod_hi_nz,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem,
  output logic          div_zero
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod;

  assign prod       = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
  assign prod_lo    = prod[DW-1:0];
  assign prod_hi_nz = |prod[PW-1:DW];
  assign div_zero   = (b == '0);
  assign quot       = div_zero ? {DW{1'b1}} : a / b;
  assign rem        = div_zero ? {DW{1'b1}} : a % b;
endmodule

// File: rtl/opc_alu_logic.sv
module opc_alu_logic
  import opc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      OP_NOT:  y = ~a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NAND: y = ~(a & b);
      OP_NOR:  y = ~(a | b);
      OP_XNOR: y = ~(a ^ b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/opc_alu.sv
module opc_alu
  import opc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_result,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_wr
);
  alu_op_e       op;
  logic [DW-1:0] as_b;
  logic          as_sub;
  logic [DW-1:0] as_sum;
  logic          as_carry;
  logic          as_ovf;
  logic [DW-1:0] md_lo, md_quot, md_rem;
  logic          md_hi_nz, md_dz;
  logic [DW-1:0] lg_y;

  logic [DW-1:0] nx_result;
  logic [DW-1:0] flag_src;
  alu_flags_t    nx_flags;
  logic          nx_wr;

  opc_alu_decode u_dec (
    .opcode (in_opcode),
    .op     (op)
  );

  // increment/decrement reuse the adder with a constant one
  assign as_b   = (op == OP_INC || op == OP_DEC) ? {{(DW-1){1'b0}}, 1'b1} : in_b;
  assign as_sub = (op == OP_DEC) || (op == OP_SUB) || (op == OP_CMP);

  opc_alu_addsub #(.DW(DW)) u_as (
    .a     (in_a),
    .b     (as_b),
    .sub   (as_sub),
    .sum   (as_sum),
    .carry (as_carry),
    .ovf   (as_ovf)
  );

  opc_alu_muldiv #(.DW(DW)) u_md (
    .a          (in_a),
    .b          (in_b),
    .prod_lo    (md_lo),
    .prod_hi_nz (md_hi_nz),
    .quot       (md_quot),
    .rem        (md_rem),
    .div_zero   (md_dz)
  );

  opc_alu_logic #(.DW(DW)) u_lg (
    .op (op),
    .a  (in_a),
    .b  (in_b),
    .y  (lg_y)
  );

  always_comb begin
    nx_result = '0;
    flag_src  = '0;
    nx_wr     = 1'b1;
    nx_flags  = '0;
    unique case (op)
      OP_INC, OP_DEC, OP_ADD, OP_SUB: begin
        nx_result      = as_sum;
        nx_flags.carry = as_carry;
        nx_flags.ovf   = as_ovf;
      end
      OP_CMP: begin
        nx_wr          = 1'b0;
        nx_flags.carry = as_carry;
        nx_flags.ovf   = as_ovf;
      end
      OP_MUL: begin
        nx_result      = md_lo;
        nx_flags.carry = md_hi_nz;
      end
      OP_DIV: begin
        nx_result     = md_quot;
        nx_flags.derr = md_dz;
      end
      OP_MOD: begin
        nx_result     = md_rem;
        nx_flags.derr = md_dz;
      end
      OP_NONE: begin
        nx_wr = 1'b0;
      end
      default: begin
        nx_result = lg_y;
      end
    endcase
    // compare derives zero/sign from the difference, others from the result
    flag_src      = (op == OP_CMP) ? as_sum : nx_result;
    nx_flags.zero = (flag_src == '0);
    nx_flags.neg  = flag_src[DW-1];
    if (op == OP_NONE) nx_flags = alu_flags_t'(in_flags);
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      out_wr     <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nx_result;
        out_flags  <= nx_flags;
        out_wr     <= nx_wr;
      end
    end
  end
endmodule

// File: rtl/opc_alu_chk.sv
module opc_alu_chk #(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_opcode,
  input logic [DW-1:0]    in_b,
  input logic [4:0]       in_flags,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_result,
  input logic [4:0]       out_flags,
  input logic             out_wr
);
  logic take;
  logic listed;
  logic is_logic;

  assign take     = in_valid && in_ready;
  assign listed   = (in_opcode inside {8'h01, 8'h02, 8'h03}) ||
                    (in_opcode[3:0] == 4'h0 && in_opcode[7:4] >= 4'h1 &&
                     in_opcode[7:4] <= 4'hC);
  assign is_logic = in_opcode inside {8'h60, 8'h70, 8'h80, 8'h90, 8'hA0, 8'hB0};

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_flags) && $stable(out_wr)));

  // R6
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_opcode == 8'h40 || in_opcode == 8'h50) && in_b == '0)
      |=> (out_result == {DW{1'b1}} && out_flags[4] && !out_flags[3] && !out_flags[1]));

  // R7
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_logic) |=> (!out_flags[1] && !out_flags[3] && out_wr));

  // R8
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_opcode == 8'hC0) |=> (!out_wr && out_result == '0));

  // R9
  unlisted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !listed) |=> (!out_wr && out_result == '0 && out_flags == $past(in_flags)));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr) |-> (out_flags[0] == (out_result == '0) &&
                               out_flags[2] == out_result[DW-1]));
endmodule

bind opc_alu opc_alu_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_opcode  (in_opcode),
  .in_b       (in_b),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags),
  .out_wr     (out_wr)
);

// File: tb/opc_alu_tb.sv
module opc_alu_tb;
  typedef struct {
    logic [7:0] res;
    logic [4:0] flg;
    logic       wr;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_opcode = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic [4:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [4:0] out_flags;
  logic       out_wr;

  int   checks = 0;
  int   errors = 0;
  int   sent = 0;
  int   got = 0;
  int   cyc = 0;
  bit   done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  opc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .out_wr(out_wr)
  );

  // Reference model; flag word R11: {derr, ovf, sign, carry, zero}
  function automatic exp_t model(logic [7:0] op, logic [7:0] a, logic [7:0] b,
                                 logic [4:0] fin);
    exp_t e;
    int ua = int'(a), ub = int'(b), t;
    logic [7:0] r = 8'h00, zsrc;
    logic c = 0, v = 0, d = 0;
    e.wr = 1'b1;
    case (op)
      8'h01: begin t = ua + 1; r = t[7:0]; c = (ua == 255); v = (ua == 127); e.req = "R2"; end
      8'h02: begin t = ua - 1; r = t[7:0]; c = (ua == 0); v = (ua == 128); e.req = "R2"; end
      8'h03: begin r = ~a; e.req = "R2"; end
      8'h10: begin t = ua + ub; r = t[7:0]; c = (t > 255);
                   v = (a[7] == b[7]) && (r[7] != a[7]); e.req = "R3"; end
      8'h20, 8'hC0: begin t = ua - ub; r = t[7:0]; c = (ua < ub);
                   v = (a[7] != b[7]) && (r[7] != a[7]); e.req = (op == 8'h20) ? "R3" : "R8"; end
      8'h30: begin t = ua * ub; r = t[7:0]; c = (t > 255); e.req = "R4"; end
      8'h40, 8'h50: begin
        if (ub == 0) begin r = 8'hFF; d = 1; e.req = "R6"; end
        else begin t = (op == 8'h40) ? ua / ub : ua % ub; r = t[7:0]; e.req = "R5"; end
      end
      8'h60: begin r = a & b;    e.req = "R7"; end
      8'h70: begin r = a | b;    e.req = "R7"; end
      8'h80: begin r = a ^ b;    e.req = "R7"; end
      8'h90: begin r = ~(a & b); e.req = "R7"; end
      8'hA0: begin r = ~(a | b); e.req = "R7"; end
      8'hB0: begin r = ~(a ^ b); e.req = "R7"; end
      default: begin
        e.res = 8'h00; e.flg = fin; e.wr = 1'b0; e.req = "R9";
        return e;
      end
    endcase
    zsrc  = r;                       // R10: zero and sign from result
    e.flg = {d, v, zsrc[7], c, zsrc == 8'h00};
    e.res = r;
    if (op == 8'hC0) begin e.res = 8'h00; e.wr = 1'b0; end
    return e;
  endfunction

  task automatic send(input logic [7:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic [4:0] fin);
    in_valid = 1'b1; in_opcode = op; in_a = a; in_b = b; in_flags = fin;
    forever begin
      if (in_ready) begin
        sb.push_back(model(op, a, b, fin));
        sent++;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // consumer stall pattern, changes well away from both edges
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = ((cyc % 7) != 3) && ((cyc % 11) != 5) && !(cyc > 300 && cyc < 310);
  end

  // monitor
  logic       held_v = 0;
  logic [7:0] held_r;
  logic [4:0] held_f;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v && out_valid) begin
        checks++;
        if (out_result !== held_r || out_flags !== held_f) begin
          errors++;
          $display("FAIL R1 held output changed: got %h/%h exp %h/%h",
                   out_result, out_flags, held_r, held_f);
        end
      end
      held_v = out_valid && !out_ready;
      held_r = out_result; held_f = out_flags;
      if (out_valid && out_ready) begin
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected response: got %h exp none", out_result);
        end else begin
          e = sb.pop_front();
          got++;
          if (out_result !== e.res || out_flags !== e.flg || out_wr !== e.wr) begin
            errors++;
            $display("FAIL %s op result/flags/wr: got %h/%b/%b exp %h/%b/%b",
                     e.req, out_result, out_flags, out_wr, e.res, e.flg, e.wr);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state: got v=%b r=%b exp v=0 r=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2 unary corners, B must be ignored
    send(8'h01, 8'h05, 8'hAA, 5'h00);
    send(8'h01, 8'hFF, 8'h13, 5'h00);
    send(8'h01, 8'h7F, 8'h00, 5'h00);
    send(8'h02, 8'h00, 8'h55, 5'h00);
    send(8'h02, 8'h80, 8'h01, 5'h00);
    send(8'h02, 8'h01, 8'hFF, 5'h00);
    send(8'h03, 8'h5A, 8'h00, 5'h00);
    send(8'h03, 8'hFF, 8'h00, 5'h00);
    // R3
    send(8'h10, 8'h7F, 8'h01, 5'h00);
    send(8'h10, 8'hFF, 8'h01, 5'h00);
    send(8'h10, 8'h10, 8'h20, 5'h00);
    send(8'h20, 8'h05, 8'h07, 5'h00);
    send(8'h20, 8'h80, 8'h01, 5'h00);
    send(8'h20, 8'h33, 8'h33, 5'h00);
    // R4
    send(8'h30, 8'h10, 8'h10, 5'h00);
    send(8'h30, 8'h0C, 8'h0B, 5'h00);
    send(8'h30, 8'hFF, 8'hFF, 5'h00);
    // R5, R6 and R10 clearing of a stale divide error
    send(8'h40, 8'h64, 8'h07, 5'h10);
    send(8'h50, 8'h64, 8'h07, 5'h10);
    send(8'h40, 8'h05, 8'h09, 5'h00);
    send(8'h40, 8'h2A, 8'h00, 5'h00);
    send(8'h50, 8'h00, 8'h00, 5'h0F);
    // R7
    for (int k = 6; k <= 11; k++) send({k[3:0], 4'h0}, 8'hC3, 8'hA5, 5'h0A);
    // R8
    send(8'hC0, 8'h42, 8'h42, 5'h00);
    send(8'hC0, 8'h10, 8'h20, 5'h00);
    send(8'hC0, 8'h90, 8'h10, 5'h00);
    // R9 unlisted codes keep the incoming flags
    send(8'h00, 8'h12, 8'h34, 5'h15);
    send(8'h04, 8'h12, 8'h34, 5'h0B);
    send(8'h11, 8'h12, 8'h34, 5'h1F);
    send(8'hD0, 8'h12, 8'h34, 5'h06);
    send(8'hFF, 8'h12, 8'h34, 5'h11);
    // full opcode sweep, R11 layout checked on every item
    for (int op = 0; op < 256; op++) send(op[7:0], 8'h3C, 8'h05, op[4:0]);
    for (int op = 0; op < 256; op++) send(op[7:0], 8'hE7, 8'hF9, ~op[4:0]);
    repeat (40) @(negedge clk);
    checks++;
    if (got != sent) begin
      errors++;
      $display("FAIL R1 response count: got %0d exp %0d", got, sent);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule